// File: doc/BRIEF.md
# Bit Offset Realigner

This block streams bytes out of a byte-wide memory whose content is not byte-aligned: the wanted bit stream starts at a known byte index and a known bit offset inside that byte. On a start strobe it latches the base index, the offset and the number of bytes to produce. It then reads the memory strictly in order and emits bytes shifted so that the bit at the given offset becomes the most significant bit of the first output byte. With a sync word located by an earlier stage, the output begins with that word on a byte boundary.

Each output byte is assembled from two consecutive source bytes. The newer byte of one pair is kept inside the block and becomes the older byte of the next pair, so every source byte is fetched exactly once. Each output carries the index it belongs to, counted from the base. A consumer can therefore forward the bytes to a host link, or write them back to the same memory to correct a stored sector in place.

Top module: `bit_realign`

## Requirements
- R1: A start strobe while idle latches the base index, bit offset and byte count. A start strobe that arrives while a run is active is ignored and leaves that run's output unchanged.
- R2: Output byte k equals bits [15:8] of the 16-bit value {S[b+k], S[b+k+1]} shifted left by n. Here S is memory, b is the base index and n is the offset in 0..7, and the bit order is MSB first. With n = 0, the bytes come out unchanged.
- R3: For a count L > 0, the block issues exactly L+1 read requests, at addresses b, b+1, ..., b+L in that order. It never has more than one request outstanding: a new request is issued only after rd_valid_i has returned the previous byte.
- R4: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_addr_o stay stable. No read request is issued while out_valid_o is high.
- R5: out_addr_o equals b+k while output byte k is presented, so the output can be written back in place.
- R6: done_o is a single-cycle pulse in the cycle after the final byte is accepted. With L = 0, done_o pulses in the cycle after the strobe, and no read and no output occur.
- R7: When the 16-bit word 0x4489 starts at bit offset n of byte b, the first two output bytes are 0x44 and 0x89. A full sector of 1088 bytes can be produced in one run.
- R8: After reset, out_valid_o, rd_req_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| start_addr_i | input | ADDR_W | Byte index holding the first wanted bit |
| bit_ofs_i | input | OFS_W | Bit offset n inside the first byte, counted from the MSB |
| byte_cnt_i | input | LEN_W | Number of aligned bytes to produce |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address, valid with rd_req_o |
| rd_valid_i | input | 1 | Read data returned |
| rd_data_i | input | BYTE_W | Read data |
| out_valid_o | output | 1 | Aligned byte available |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_data_o | output | BYTE_W | Aligned byte |
| out_addr_o | output | ADDR_W | Index of the aligned byte, for write-back in place |
| done_o | output | 1 | Run complete pulse |

## Verification
The checks rely on the memory returning exactly one rd_valid_i for each request, at least one cycle after that request, and never raising rd_valid_i on its own. The bench memory model follows this rule with response latencies of one to four cycles. The checks also assume that the source bytes stay unchanged during a run, so the bench writes its memory image only between runs. Back-pressure is varied with eight-cycle ready patterns, including long low stretches, so that stalls land on every phase of the read and hold sequence.

// File: rtl/rv_pkg.sv
// Shared types for the bit offset realigner.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a start strobe
        ST_FIRST = 2'd1,   // waiting for the first (older) source byte
        ST_NEXT  = 2'd2,   // waiting for the next (newer) source byte
        ST_HOLD  = 2'd3    // presenting an aligned byte
    } rv_state_e;
endpackage

// File: rtl/rv_funnel.sv
// Funnel shifter: forms one aligned byte from two consecutive source bytes.
// Assumes: older_i precedes newer_i in the bit stream, MSB first.
module rv_funnel #(
    parameter int BYTE_W = 8,
    parameter int OFS_W  = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] older_i,
    input  logic [BYTE_W-1:0] newer_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int PAIR_W = 2 * BYTE_W;

    logic [PAIR_W-1:0] pair_sh;

    // Shift the byte pair toward the older end and keep the upper byte.
    always_comb begin
        pair_sh = {older_i, newer_i} << ofs_i;
        byte_o  = pair_sh[PAIR_W-1:BYTE_W];
    end
endmodule

// File: rtl/rv_hold.sv
// Two-byte holding store: the older byte and the newer byte of the pair.
// Assumes: the load and advance controls are mutually exclusive.
module rv_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_old_i,
    input  logic              load_new_i,
    input  logic              advance_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [BYTE_W-1:0] old_o,
    output logic [BYTE_W-1:0] new_o
);
    // Capture returned bytes; on advance the newer byte becomes the older one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_o <= '0;
            new_o <= '0;
        end else begin
            if (load_old_i) old_o <= din_i;
            if (advance_i)  old_o <= new_o;
            if (load_new_i) new_o <= din_i;
        end
    end
endmodule

// File: rtl/rv_ctrl.sv
// Sequencer: latches a job, issues strictly sequential reads with one
// request outstanding, holds each aligned byte until accepted, pulses done.
// Assumes: each read request gets exactly one rd_valid_i, at least one cycle later.
module rv_ctrl
    import rv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [OFS_W-1:0]  bit_ofs_i,
    input  logic [LEN_W-1:0]  byte_cnt_i,
    input  logic              rd_valid_i,
    input  logic              out_ready_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              out_valid_o,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              done_o,
    output logic              load_old_o,
    output logic              load_new_o,
    output logic              advance_o
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    rv_state_e         state_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              last_byte;
    logic              accept;

    // Decode handshakes and the holding-store controls from the state.
    always_comb begin
        out_valid_o = (state_q == ST_HOLD);
        accept      = out_valid_o && out_ready_i;
        last_byte   = (cnt_q == len_q - LEN_ONE);
        load_old_o  = (state_q == ST_FIRST) && rd_valid_i;
        load_new_o  = (state_q == ST_NEXT) && rd_valid_i;
        advance_o   = accept && !last_byte;
    end

    // Job sequencing, read address generation and output index tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_req_o   <= 1'b0;
            rd_addr_o  <= '0;
            rd_ptr_q   <= '0;
            out_addr_o <= '0;
            ofs_o      <= '0;
            len_q      <= '0;
            cnt_q      <= '0;
            done_o     <= 1'b0;
        end else begin
            rd_req_o <= 1'b0;
            done_o   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ofs_o      <= bit_ofs_i;
                        len_q      <= byte_cnt_i;
                        cnt_q      <= '0;
                        out_addr_o <= start_addr_i;
                        if (byte_cnt_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            rd_req_o  <= 1'b1;
                            rd_addr_o <= start_addr_i;
                            rd_ptr_q  <= start_addr_i + ADDR_ONE;
                            state_q   <= ST_FIRST;
                        end
                    end
                end
                ST_FIRST: begin
                    if (rd_valid_i) begin
                        rd_req_o  <= 1'b1;
                        rd_addr_o <= rd_ptr_q;
                        rd_ptr_q  <= rd_ptr_q + ADDR_ONE;
                        state_q   <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (rd_valid_i) state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (accept) begin
                        if (last_byte) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            rd_req_o   <= 1'b1;
                            rd_addr_o  <= rd_ptr_q;
                            rd_ptr_q   <= rd_ptr_q + ADDR_ONE;
                            cnt_q      <= cnt_q + LEN_ONE;
                            out_addr_o <= out_addr_o + ADDR_ONE;
                            state_q    <= ST_NEXT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bit_realign.sv
// Bit offset realigner top: reads an unaligned byte stream once, in order,
// and emits bytes shifted left by a fixed sub-byte offset.
// Assumes: a single-port memory that answers each request exactly once.
module bit_realign #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int BYTE_W = 8,
    localparam int OFS_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [OFS_W-1:0]  bit_ofs_i,
    input  logic [LEN_W-1:0]  byte_cnt_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [BYTE_W-1:0] out_data_o,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic              done_o
);
    logic [OFS_W-1:0]  ofs_w;
    logic              load_old_w;
    logic              load_new_w;
    logic              advance_w;
    logic [BYTE_W-1:0] old_w;
    logic [BYTE_W-1:0] new_w;

    rv_ctrl #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W),
        .OFS_W (OFS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_addr_i(start_addr_i),
        .bit_ofs_i   (bit_ofs_i),
        .byte_cnt_i  (byte_cnt_i),
        .rd_valid_i  (rd_valid_i),
        .out_ready_i (out_ready_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .out_valid_o (out_valid_o),
        .out_addr_o  (out_addr_o),
        .ofs_o       (ofs_w),
        .done_o      (done_o),
        .load_old_o  (load_old_w),
        .load_new_o  (load_new_w),
        .advance_o   (advance_w)
    );

    rv_hold #(
        .BYTE_W(BYTE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_old_i(load_old_w),
        .load_new_i(load_new_w),
        .advance_i (advance_w),
        .din_i     (rd_data_i),
        .old_o     (old_w),
        .new_o     (new_w)
    );

    rv_funnel #(
        .BYTE_W(BYTE_W),
        .OFS_W (OFS_W)
    ) u_funnel (
        .older_i(old_w),
        .newer_i(new_w),
        .ofs_i  (ofs_w),
        .byte_o (out_data_o)
    );
endmodule

// File: rtl/rv_checker.sv
// Protocol checker for bit_realign, attached with bind.
// Assumes: the memory answers each request once and never answers unasked.
module rv_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_valid_i,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [BYTE_W-1:0] out_data_o,
    input logic [ADDR_W-1:0] out_addr_o,
    input logic              done_o
);
    logic              pending_q;
    logic              have_rd_q;
    logic [ADDR_W-1:0] last_rd_q;
    logic              have_acc_q;
    logic [ADDR_W-1:0] acc_addr_q;

    // Track the outstanding read and the previous read and accept indices of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            have_rd_q  <= 1'b0;
            last_rd_q  <= '0;
            have_acc_q <= 1'b0;
            acc_addr_q <= '0;
        end else begin
            if (rd_req_o)        pending_q <= 1'b1;
            else if (rd_valid_i) pending_q <= 1'b0;
            if (rd_req_o) begin
                have_rd_q <= 1'b1;
                last_rd_q <= rd_addr_o;
            end
            if (out_valid_o && out_ready_i) begin
                have_acc_q <= 1'b1;
                acc_addr_q <= out_addr_o;
            end
            if (done_o) begin
                have_rd_q  <= 1'b0;
                have_acc_q <= 1'b0;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid_o && !rd_req_o && !done_o); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !pending_q); // R3

    AST_READ_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && have_rd_q |-> rd_addr_o == last_rd_q + ADDR_W'(1)); // R3

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_addr_o)); // R4

    AST_NO_READ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !rd_req_o); // R4

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) && have_acc_q |-> out_addr_o == acc_addr_q + ADDR_W'(1)); // R5

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(out_valid_o && out_ready_i) || $past(start_i)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
endmodule

bind bit_realign rv_checker #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_addr_o (out_addr_o),
    .done_o     (done_o)
);

// File: tb/bit_realign_tb.sv
`timescale 1ns/1ps
module bit_realign_tb;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int MEM_N  = 2048;

    typedef struct packed {
        logic [15:0] base;
        logic [2:0]  ofs;
        logic [15:0] len;
        logic [3:0]  lat;
        logic [7:0]  rdy;
        logic        sync;
        logic        poke;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{base:16'd10,   ofs:3'd0, len:16'd8,    lat:4'd1, rdy:8'hFF,        sync:1'b0, poke:1'b0},
        '{base:16'd100,  ofs:3'd3, len:16'd20,   lat:4'd1, rdy:8'hFF,        sync:1'b1, poke:1'b0},
        '{base:16'd300,  ofs:3'd7, len:16'd9,    lat:4'd3, rdy:8'b1010_0110, sync:1'b1, poke:1'b1},
        '{base:16'd517,  ofs:3'd1, len:16'd33,   lat:4'd2, rdy:8'b1100_0011, sync:1'b0, poke:1'b0},
        '{base:16'd40,   ofs:3'd5, len:16'd1088, lat:4'd1, rdy:8'b1110_1111, sync:1'b1, poke:1'b0},
        '{base:16'd1500, ofs:3'd6, len:16'd1,    lat:4'd4, rdy:8'h0F,        sync:1'b1, poke:1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [2:0]        bit_ofs_i = '0;
    logic [LEN_W-1:0]  byte_cnt_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_valid_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              out_valid_o;
    logic              out_ready_i = 1'b0;
    logic [7:0]        out_data_o;
    logic [ADDR_W-1:0] out_addr_o;
    logic              done_o;

    bit_realign #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .bit_ofs_i(bit_ofs_i), .byte_cnt_i(byte_cnt_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
        .out_addr_o(out_addr_o), .done_o(done_o)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [7:0] mem [MEM_N];

    // Current job as seen by the collector
    int         cur_base = 0;
    int         cur_ofs  = 0;
    int         cur_len  = 0;
    int         cur_lat  = 1;
    logic [7:0] cur_rdy  = 8'hFF;
    int         start_cyc = 0;
    int         nacc = 0, nreads = 0, exp_rd = 0, last_acc_cyc = 0;
    bit         done_seen = 1'b0;
    bit         active = 1'b0;
    logic [7:0] first_two [2];

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, expv, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: one answer per request, after cur_lat cycles
    int         pend_cnt = 0;
    logic [ADDR_W-1:0] pend_addr = '0;
    always @(posedge clk) begin
        rd_valid_i <= 1'b0;
        if (rd_req_o) begin
            pend_addr <= rd_addr_o;
            pend_cnt  <= cur_lat;
        end else if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= mem[pend_addr[10:0]];
            end
        end
    end

    // Drive ready, then observe outputs away from the active edge
    always @(negedge clk) begin
        out_ready_i = cur_rdy[cyc[2:0]];
        if (active) begin
            if (rd_req_o) begin
                chk(rd_addr_o == ADDR_W'(exp_rd), "R3 read address", int'(rd_addr_o), exp_rd);
                exp_rd++;
                nreads++;
            end
            if (out_valid_o && rd_req_o)
                chk(1'b0, "R4 read during hold", 1, 0);
            if (out_valid_o && out_ready_i) begin
                logic [15:0] pair;
                int a;
                a = (cur_base + nacc) % MEM_N;
                pair = {mem[a], mem[(a + 1) % MEM_N]} << cur_ofs;
                chk(out_data_o == pair[15:8], "R2 aligned byte", int'(out_data_o), int'(pair[15:8]));
                chk(out_addr_o == ADDR_W'(cur_base + nacc), "R5 output index", int'(out_addr_o), cur_base + nacc);
                if (nacc < 2) first_two[nacc] = out_data_o;
                nacc++;
                last_acc_cyc = cyc;
            end
            if (done_o) begin
                done_seen = 1'b1;
                chk(nacc == cur_len, "R6 bytes before done", nacc, cur_len);
                chk(nreads == (cur_len == 0 ? 0 : cur_len + 1), "R3 read count", nreads,
                    cur_len == 0 ? 0 : cur_len + 1);
                if (cur_len == 0)
                    chk(cyc == start_cyc + 1, "R6 done after empty start", cyc, start_cyc + 1);
                else
                    chk(cyc == last_acc_cyc + 1, "R6 done after final accept", cyc, last_acc_cyc + 1);
            end
        end
    end

    task automatic load_mem(input int base, input int ofs, input bit sync);
        logic [23:0] w, m;
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i * 29 + 7) ^ 8'(i >> 4);
        if (sync) begin
            w = {mem[base], mem[base + 1], mem[base + 2]};
            m = 24'hFFFF00 >> ofs;
            w = (w & ~m) | (24'h448900 >> ofs);
            {mem[base], mem[base + 1], mem[base + 2]} = w;
        end
    endtask

    task automatic run_job(input vec_t v);
        load_mem(int'(v.base), int'(v.ofs), v.sync);
        @(negedge clk);
        cur_base = int'(v.base); cur_ofs = int'(v.ofs); cur_len = int'(v.len);
        cur_lat = int'(v.lat); cur_rdy = v.rdy;
        nacc = 0; nreads = 0; exp_rd = int'(v.base); done_seen = 1'b0; active = 1'b1;
        start_i = 1'b1; start_addr_i = v.base; bit_ofs_i = v.ofs; byte_cnt_i = LEN_W'(v.len);
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 20000 && !done_seen; i++) begin
            @(negedge clk);
            if (v.poke && i == 12) begin   // R1: strobe while busy, other job
                start_i = 1'b1; start_addr_i = 16'd0; bit_ofs_i = 3'd2; byte_cnt_i = 12'd3;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk(done_seen, "R6 run completes", int'(done_seen), 1);
        if (v.sync && v.len >= 2) begin
            chk(first_two[0] == 8'h44, "R7 sync first byte", int'(first_two[0]), 8'h44);
            chk(first_two[1] == 8'h89, "R7 sync second byte", int'(first_two[1]), 8'h89);
        end else if (v.sync) begin
            chk(first_two[0] == 8'h44, "R7 sync first byte", int'(first_two[0]), 8'h44);
        end
        @(negedge clk);
        active = 1'b0;
    endtask

    initial begin
        #(150000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(!out_valid_o, "R8 out_valid after reset", int'(out_valid_o), 0);
        chk(!rd_req_o,    "R8 rd_req after reset",    int'(rd_req_o), 0);
        chk(!done_o,      "R8 done after reset",      int'(done_o), 0);

        // Table of jobs: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NVEC; k++) run_job(VECS[k]);

        // Directed: zero-length job, done with no reads (R6)
        run_job('{base:16'd77, ofs:3'd4, len:16'd0, lat:4'd1, rdy:8'hFF, sync:1'b0, poke:1'b0});
        // Directed: back-to-back jobs, pass-through offset zero with heavy stall (R2, R4)
        run_job('{base:16'd2000, ofs:3'd0, len:16'd40, lat:4'd2, rdy:8'b1000_0001, sync:1'b1, poke:1'b0});

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule